// File: doc/BRIEF.md
# Sampled PC Histogram Unit

This block builds an execution profile in hardware. It divides a window of instruction addresses into equal, aligned blocks and keeps one saturating counter (a bucket) for each block. A sampling counter starts at the negative of a programmed period and counts up. In time mode it counts once per clock. In event mode it counts once per event pulse. On each wrap through zero, the block takes the program counter seen in that cycle, converts it to a bucket number and adds one to that bucket with a read-modify-write. The counter then reloads to the negative period.

Software, or a neighbouring block, sets the mode, the period, the window base and the block-size shift. It then lets the target run and reads buckets out through a combinational readout port. A clear command zeroes every bucket one per cycle and reloads the sampling counter. Reset starts the same sweep.

Top module: `pc_hist`

## Requirements
- R1: A clear pulse on `clr_i` (and the end of reset) raises `busy_o` for exactly NB cycles. When it falls, every bucket reads zero.
- R2: After a clear, the first sample is taken on exactly the P-th counted tick or event, where P is the effective period.
- R3: With `mode_i` = 2'b01 (time), every clock cycle counts as one tick. N cycles produce floor(N/P) samples.
- R4: With `mode_i` = 2'b10 (event), only cycles with `evt_i` high count. Cycles without `evt_i` do not advance the counter.
- R5: With `mode_i` = 2'b00 or 2'b11 (off), the counter holds its value and no sample is taken. Counting resumes from the held value.
- R6: A sampled PC at or above `base_i` maps to bucket (pc − base) >> `shift_i`. All addresses in one aligned block share a bucket.
- R7: A PC below `base_i`, or one whose block number is NB−1 or more, is counted in the last bucket, NB−1.
- R8: A bucket that holds its maximum value stays at that value when it is incremented again.
- R9: Samples arriving every second cycle are all counted. None is dropped while an earlier update is in progress.
- R10: A programmed period of 0 or 1 acts as a period of 2.
- R11: While `busy_o` is high, ticks and events are ignored, and none of them adds to a bucket after the clear ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high; starts a clear sweep |
| mode_i | input | 2 | 00/11 off, 01 time ticks, 10 event pulses |
| period_i | input | PER_W | Sampling period in ticks or events |
| base_i | input | PC_W | Lowest address of the profiled window |
| shift_i | input | SH_W | log2 of the block size in address units |
| pc_i | input | PC_W | Current program counter |
| evt_i | input | 1 | Qualifying event, one count per cycle high |
| clr_i | input | 1 | Clear command pulse |
| busy_o | output | 1 | High while the clear sweep runs |
| rd_idx_i | input | IDX_W | Bucket number to read |
| rd_data_o | output | BKT_W | Content of the selected bucket |

## Verification
A sampling counter that is off by one shows as a bucket total one higher or one lower than floor(ticks/period), visible three cycles after the last tick. The exact-boundary runs catch that. A wrong bucket mapping puts counts into a neighbouring or overflow bucket, and this shows as soon as the update lands two cycles after the sample. A lost or doubled update shows as a shortfall or an excess in the back-to-back run. A clear sweep that stops early or lets samples through leaves nonzero buckets, or a wrong busy length, as soon as `busy_o` falls.

// File: rtl/pch_pkg.sv
package pch_pkg;
  typedef enum logic [1:0] {
    MODE_OFF   = 2'b00,
    MODE_TIME  = 2'b01,
    MODE_EVENT = 2'b10,
    MODE_IDLE  = 2'b11
  } mode_e;

  typedef enum logic [1:0] {
    ENG_IDLE = 2'b00,
    ENG_READ = 2'b01,
    ENG_WRITE = 2'b10
  } eng_state_e;
endpackage

// File: rtl/pch_binner.sv
module pch_binner #(
  parameter int PC_W  = 32,
  parameter int NB    = 64,
  parameter int IDX_W = 6,
  parameter int SH_W  = 5
) (
  input  logic [PC_W-1:0]  pc_i,
  input  logic [PC_W-1:0]  base_i,
  input  logic [SH_W-1:0]  shift_i,
  output logic [IDX_W-1:0] idx_o
);
  localparam logic [IDX_W-1:0] SPILL = IDX_W'(NB - 1);

  function automatic logic [IDX_W-1:0] bucket_of(
    input logic [PC_W-1:0] pc,
    input logic [PC_W-1:0] base,
    input logic [SH_W-1:0] sh
  );
    logic [PC_W-1:0] blk;
    blk = (pc - base) >> sh;
    if (pc < base)                return SPILL;
    else if (blk >= PC_W'(NB - 1)) return SPILL;
    else                           return blk[IDX_W-1:0];
  endfunction

  assign idx_o = bucket_of(pc_i, base_i, shift_i);
endmodule

// File: rtl/pch_sampler.sv
module pch_sampler
  import pch_pkg::*;
#(
  parameter int PER_W = 16,
  parameter int IDX_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             hold_i,
  input  logic [1:0]       mode_i,
  input  logic             evt_i,
  input  logic [PER_W-1:0] period_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic             sample_vld_o,
  output logic [IDX_W-1:0] sample_idx_o
);
  localparam logic [PER_W-1:0] MIN_PER = PER_W'(2);

  // negative of the effective period; short periods are raised to two
  function automatic logic [PER_W-1:0] reload_of(input logic [PER_W-1:0] p);
    logic [PER_W-1:0] eff;
    eff = (p < MIN_PER) ? MIN_PER : p;
    return PER_W'(0) - eff;
  endfunction

  logic [PER_W-1:0] cnt_q;
  logic             tick;
  logic             wrap;
  logic [PER_W-1:0] reload;

  assign reload = reload_of(period_i);
  assign tick   = !hold_i && ((mode_i == MODE_TIME) ||
                              ((mode_i == MODE_EVENT) && evt_i));
  assign wrap   = tick && (&cnt_q);

  always_ff @(posedge clk_i) begin
    if (rst_i || hold_i) begin
      cnt_q        <= reload;
      sample_vld_o <= 1'b0;
      sample_idx_o <= '0;
    end else begin
      sample_vld_o <= wrap;
      sample_idx_o <= idx_i;
      if (tick) cnt_q <= wrap ? reload : cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/pch_bucket_store.sv
module pch_bucket_store
  import pch_pkg::*;
#(
  parameter int NB    = 64,
  parameter int IDX_W = 6,
  parameter int BKT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             clr_i,
  input  logic             req_vld_i,
  input  logic [IDX_W-1:0] req_idx_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [BKT_W-1:0] rd_data_o,
  output logic             busy_o,
  output logic             clr_last_o,
  output logic             upd_wr_o,
  output logic [BKT_W-1:0] upd_new_o,
  output logic             pend_vld_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NB - 1);

  function automatic logic [BKT_W-1:0] sat_inc(input logic [BKT_W-1:0] v);
    return (&v) ? v : v + 1'b1;
  endfunction

  logic [BKT_W-1:0] mem_q [NB];
  eng_state_e       state_q;
  logic [IDX_W-1:0] idx_q;
  logic [BKT_W-1:0] old_q;
  logic             pend_q;
  logic [IDX_W-1:0] pend_idx_q;
  logic             busy_q;
  logic [IDX_W-1:0] ptr_q;
  logic             take;
  logic [IDX_W-1:0] take_idx;

  assign rd_data_o  = mem_q[rd_idx_i];
  assign busy_o     = busy_q;
  assign clr_last_o = busy_q && (ptr_q == LAST);
  assign pend_vld_o = pend_q;
  assign upd_wr_o   = (state_q == ENG_WRITE) && !clr_i;
  assign upd_new_o  = sat_inc(old_q);
  // the pending sample is older, so it goes first
  assign take       = pend_q || req_vld_i;
  assign take_idx   = pend_q ? pend_idx_q : req_idx_i;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      state_q    <= ENG_IDLE;
      idx_q      <= '0;
      old_q      <= '0;
      pend_q     <= 1'b0;
      pend_idx_q <= '0;
      busy_q     <= 1'b1;
      ptr_q      <= '0;
    end else if (busy_q) begin
      state_q <= ENG_IDLE;
      pend_q  <= 1'b0;
      ptr_q   <= ptr_q + 1'b1;
      if (ptr_q == LAST) busy_q <= 1'b0;
    end else if (clr_i) begin
      state_q <= ENG_IDLE;
      pend_q  <= 1'b0;
      busy_q  <= 1'b1;
      ptr_q   <= '0;
    end else begin
      unique case (state_q)
        ENG_READ: begin
          old_q   <= mem_q[idx_q];
          state_q <= ENG_WRITE;
          if (req_vld_i) begin
            pend_q     <= 1'b1;
            pend_idx_q <= req_idx_i;
          end
        end
        default: begin
          if (take) begin
            idx_q   <= take_idx;
            state_q <= ENG_READ;
            pend_q  <= pend_q && req_vld_i;
            if (pend_q) pend_idx_q <= req_idx_i;
          end else begin
            state_q <= ENG_IDLE;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (busy_q)        mem_q[ptr_q] <= '0;
    else if (upd_wr_o) mem_q[idx_q] <= upd_new_o;
  end
endmodule

// File: rtl/pc_hist.sv
module pc_hist #(
  parameter int PC_W  = 32,
  parameter int NB    = 64,
  parameter int BKT_W = 16,
  parameter int PER_W = 16,
  parameter int IDX_W = $clog2(NB),
  parameter int SH_W  = $clog2(PC_W)
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic [1:0]       mode_i,
  input  logic [PER_W-1:0] period_i,
  input  logic [PC_W-1:0]  base_i,
  input  logic [SH_W-1:0]  shift_i,
  input  logic [PC_W-1:0]  pc_i,
  input  logic             evt_i,
  input  logic             clr_i,
  output logic             busy_o,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [BKT_W-1:0] rd_data_o
);
  logic [IDX_W-1:0] cur_idx;
  logic             sample_vld;
  logic [IDX_W-1:0] sample_idx;
  logic             hold;
  logic             clr_last;
  logic             upd_wr;
  logic [BKT_W-1:0] upd_new;
  logic             upd_new_nz;
  logic             pend_vld;

  assign hold       = clr_i || busy_o;
  assign upd_new_nz = |upd_new;

  pch_binner #(.PC_W(PC_W), .NB(NB), .IDX_W(IDX_W), .SH_W(SH_W)) u_bin (
    .pc_i(pc_i), .base_i(base_i), .shift_i(shift_i), .idx_o(cur_idx)
  );

  pch_sampler #(.PER_W(PER_W), .IDX_W(IDX_W)) u_smp (
    .clk_i(clk_i), .rst_i(rst_i), .hold_i(hold), .mode_i(mode_i),
    .evt_i(evt_i), .period_i(period_i), .idx_i(cur_idx),
    .sample_vld_o(sample_vld), .sample_idx_o(sample_idx)
  );

  pch_bucket_store #(.NB(NB), .IDX_W(IDX_W), .BKT_W(BKT_W)) u_store (
    .clk_i(clk_i), .rst_i(rst_i), .clr_i(clr_i),
    .req_vld_i(sample_vld), .req_idx_i(sample_idx),
    .rd_idx_i(rd_idx_i), .rd_data_o(rd_data_o),
    .busy_o(busy_o), .clr_last_o(clr_last),
    .upd_wr_o(upd_wr), .upd_new_o(upd_new), .pend_vld_o(pend_vld)
  );
endmodule

// File: rtl/pch_checker.sv
module pch_checker (
  input logic       clk_i,
  input logic       rst_i,
  input logic [1:0] mode_i,
  input logic       busy_o,
  input logic       clr_last,
  input logic       sample_vld,
  input logic       pend_vld,
  input logic       upd_wr,
  input logic       upd_new_nz
);
  // R1: the sweep runs to its last bucket before busy drops
  a_r1_sweep_hold: assert property (@(posedge clk_i) disable iff (rst_i)
    busy_o && !clr_last |=> busy_o);
  a_r1_sweep_end: assert property (@(posedge clk_i) disable iff (rst_i)
    busy_o && clr_last |=> !busy_o);
  // R11: no bucket update and no new sample during a clear
  a_r11_no_update: assert property (@(posedge clk_i) disable iff (rst_i)
    busy_o |-> !upd_wr);
  a_r11_no_sample: assert property (@(posedge clk_i) disable iff (rst_i)
    busy_o |=> !sample_vld);
  // R5: off mode yields no sample
  a_r5_off_silent: assert property (@(posedge clk_i) disable iff (rst_i)
    (mode_i == 2'b00) |=> !sample_vld);
  // R10: samples are at least two cycles apart
  a_r10_min_gap: assert property (@(posedge clk_i) disable iff (rst_i)
    sample_vld |=> !sample_vld);
  // R9: a new sample never meets a full pending slot
  a_r9_no_collision: assert property (@(posedge clk_i) disable iff (rst_i)
    sample_vld |-> !pend_vld);
  // R8: an increment never wraps to zero
  a_r8_no_wrap: assert property (@(posedge clk_i) disable iff (rst_i)
    upd_wr |-> upd_new_nz);
endmodule

bind pc_hist pch_checker u_chk (
  .clk_i(clk_i), .rst_i(rst_i), .mode_i(mode_i), .busy_o(busy_o),
  .clr_last(clr_last), .sample_vld(sample_vld), .pend_vld(pend_vld),
  .upd_wr(upd_wr), .upd_new_nz(upd_new_nz)
);

// File: tb/tb_pc_hist.sv
module tb_pc_hist;
  localparam int NB = 64;
  localparam int BW = 8;
  localparam int PW = 16;
  localparam int AW = 32;
  localparam int IW = 6;
  localparam int SW = 5;
  localparam int MAXV = (1 << BW) - 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [1:0]    mode = 2'b00;
  logic [PW-1:0] period = 16'd4;
  logic [AW-1:0] base = 32'h1000;
  logic [SW-1:0] shift = 5'd4;
  logic [AW-1:0] pc = 32'h1000;
  logic          evt = 1'b0;
  logic          clr = 1'b0;
  logic          busy;
  logic [IW-1:0] rd_idx = '0;
  logic [BW-1:0] rd_data;

  int  checks = 0;
  int  errors = 0;
  bit  done = 0;

  always #5 clk = ~clk;

  pc_hist #(.PC_W(AW), .NB(NB), .BKT_W(BW), .PER_W(PW)) dut (
    .clk_i(clk), .rst_i(rst), .mode_i(mode), .period_i(period),
    .base_i(base), .shift_i(shift), .pc_i(pc), .evt_i(evt), .clr_i(clr),
    .busy_o(busy), .rd_idx_i(rd_idx), .rd_data_o(rd_data)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic read_bkt(input int idx, output int v);
    @(negedge clk);
    rd_idx = IW'(idx);
    #1;
    v = int'(rd_data);
  endtask

  task automatic chk_bkt(input string req, input int idx, input int exp);
    int v;
    read_bkt(idx, v);
    chk(req, v, exp);
  endtask

  task automatic chk_all_zero(input string req);
    int nz = 0;
    for (int i = 0; i < NB; i++) begin
      int v;
      read_bkt(i, v);
      if (v != 0) nz++;
    end
    chk(req, nz, 0);
  endtask

  // n time ticks, then off and let the update land
  task automatic run_time(input int n);
    @(negedge clk);
    mode = 2'b01;
    repeat (n) @(negedge clk);
    mode = 2'b00;
    repeat (5) @(negedge clk);
  endtask

  task automatic pulse_evts(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); evt = 1'b1;
      @(negedge clk); evt = 1'b0;
      @(negedge clk);
    end
    repeat (5) @(negedge clk);
  endtask

  task automatic do_clear();
    int n = 0;
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
    while (busy) begin n++; @(negedge clk); end
    chk("R1 busy length after clear", n, NB);
  endtask

  task automatic t_reset();
    int n = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1 busy after reset", int'(busy), 1);
    while (busy) begin n++; @(negedge clk); end
    chk("R1 reset sweep length", n, NB);
    chk_all_zero("R1 buckets zero after reset");
  endtask

  task automatic t_time_basic();
    period = 16'd4; pc = 32'h1023;
    do_clear();
    run_time(40);
    chk_bkt("R3 time mode 40 ticks period 4", 2, 10);
    chk_bkt("R6 neighbour below untouched", 1, 0);
    chk_bkt("R6 neighbour above untouched", 3, 0);
    pc = 32'h102F;
    run_time(8);
    chk_bkt("R6 same block shares bucket", 2, 12);
  endtask

  task automatic t_overflow();
    period = 16'd2;
    do_clear();
    pc = 32'h0FFF; run_time(6);
    chk_bkt("R7 below base to last bucket", NB - 1, 3);
    pc = 32'h13F0; run_time(4);
    chk_bkt("R7 past window to last bucket", NB - 1, 5);
    pc = 32'h13EF; run_time(2);
    chk_bkt("R6 top in-range block", NB - 2, 1);
    chk_bkt("R7 last bucket unchanged", NB - 1, 5);
  endtask

  task automatic t_first_sample();
    period = 16'd5; pc = 32'h1000;
    do_clear();
    run_time(4);
    chk_bkt("R2 no sample before period", 0, 0);
    run_time(1);
    chk_bkt("R2 sample on 5th tick", 0, 1);
    repeat (20) @(negedge clk);
    chk_bkt("R5 off mode holds buckets", 0, 1);
    mode = 2'b11; repeat (10) @(negedge clk); mode = 2'b00;
    run_time(4);
    chk_bkt("R5 counter held while off", 0, 1);
    run_time(1);
    chk_bkt("R5 counting resumes from held value", 0, 2);
  endtask

  task automatic t_event();
    period = 16'd3; pc = 32'h1010;
    do_clear();
    @(negedge clk); mode = 2'b10;
    repeat (12) @(negedge clk);
    chk_bkt("R4 idle cycles do not count", 1, 0);
    pulse_evts(7);
    chk_bkt("R4 seven events period 3", 1, 2);
    pulse_evts(2);
    chk_bkt("R4 ninth event samples", 1, 3);
    mode = 2'b00;
  endtask

  task automatic t_backtoback();
    period = 16'd2; pc = 32'h1000;
    do_clear();
    run_time(40);
    chk_bkt("R9 samples every second cycle all kept", 0, 20);
  endtask

  task automatic t_min_period();
    period = 16'd0; pc = 32'h1000;
    do_clear();
    run_time(20);
    chk_bkt("R10 period 0 acts as 2", 0, 10);
    period = 16'd1;
    run_time(20);
    chk_bkt("R10 period 1 acts as 2", 0, 20);
  endtask

  task automatic t_saturate();
    period = 16'd2; pc = 32'h1000;
    do_clear();
    run_time(600);
    chk_bkt("R8 bucket saturates", 0, MAXV);
    chk_bkt("R8 other bucket untouched", 1, 0);
  endtask

  task automatic t_clear_busy();
    period = 16'd2; pc = 32'h1000;
    @(negedge clk); mode = 2'b10;
    pulse_evts(3);
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk); evt = 1'b1;
      @(negedge clk); evt = 1'b0;
    end
    while (busy) @(negedge clk);
    chk_all_zero("R11 clear wipes buckets despite events");
    pulse_evts(1);
    chk_bkt("R11 events during clear not counted", 0, 0);
    pulse_evts(1);
    chk_bkt("R2 second event after clear samples", 0, 1);
    mode = 2'b00;
  endtask

  initial begin
    t_reset();
    t_time_basic();
    t_overflow();
    t_first_sample();
    t_event();
    t_backtoback();
    t_min_period();
    t_saturate();
    t_clear_busy();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule